// File: doc/BRIEF.md
# Interleaved Vector Structure Transfer Sequencer

This block executes one decoded "multiple structures" vector load or store at a time. A command names a layout code, an element size, an alignment hint, a first vector register, a base register and an index register. The command also supplies the values of the base and index registers and the data endianness.

The block first checks the command for legality. If the command is illegal, it reports this and touches nothing. If the command is legal, it walks every element access in a fixed nested order. Each access is one memory request, and data moves between memory and the vector register file one element at a time. When the command completes, the block presents the new base address and a flag that says whether the base is to be written back.

Controller states and transitions:

- **IDLE**: accepts a command and moves to CHECK.
- **CHECK**: on a failed check, pulses `illegal` and returns to IDLE. Otherwise it goes to REQ (load) or FETCH (store).
- **FETCH**: latches the store element from the register read port, then moves to REQ.
- **REQ**: holds the memory request until `mem_ready`.
  - A load then moves to RESP.
  - A store moves to FETCH, or to FINISH after its last access.
- **RESP**: waits for `mem_rvalid`, writes the element, then returns to REQ, or to FINISH after the last access.
- **FINISH**: pulses `done` with the writeback result, then returns to IDLE.

Top module: `vst_seq`

## Requirements
- R1: Layout codes map to (registers, interleave, spacing) as follows: 0:(1,4,1), 1:(1,4,2), 2:(4,1,1), 3:(2,2,2), 4:(1,3,1), 5:(1,3,2), 6:(3,1,1), 7:(1,1,1), 8:(1,2,1), 9:(1,2,2), 10:(2,1,1). Codes 11 to 15 are illegal.
- R2: If bits 3:2 of the layout code are 01, an alignment hint of 2 or 3 is illegal. If they are 10, a hint of 3 is illegal. All other combinations are accepted.
- R3: Size code 3 (8-byte elements) is legal only when both the interleave and the spacing are 1.
- R4: When the `VREGS` parameter is 16 or less, a first register with bit 4 set is illegal.
- R5: Accesses are ordered by three nested loops: register index outermost, element index 0 to (8>>size)-1 in the middle, interleave index innermost. The target register is first + reg + spacing*interleave_index, taken modulo 32.
- R6: The first access address is the base value. Each later access is 2^size bytes above the previous one. `mem_size` carries the size code, which is log2 of the byte count.
- R7: When the interleave is 1 and the data is little-endian or byte-sized, the size is promoted to code 3. Each register then moves as one 8-byte access at element 0.
- R8: When done, an index register of 15 gives no writeback. An index register of 13 writes back base + registers*interleave*8. Any other index register writes back base + the index value. `wb_reg` is the base register number.
- R9: An illegal command raises `illegal` for exactly one cycle. It makes no memory or register-file access, never raises `done`, and leaves the block idle in the next cycle.
- R10: A memory request holds its address, size, direction and data stable until `mem_ready`. A load writes `mem_rdata` into the target element in the cycle `mem_rvalid` is high. Element e of size s occupies register bits [e*8*2^s +: 8*2^s], and memory byte A+b maps to element bits [8b +: 8].
- R11: `cmd_ready` is high only in IDLE, and a command offered while busy is ignored. `busy` stays high from the cycle after acceptance until the `done` cycle.
- R12: A store writes to memory exactly the element that the register read port returns for the target register and element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_type | input | 4 | Layout code |
| cmd_size | input | 2 | Element size code |
| cmd_align | input | 2 | Alignment hint |
| cmd_vd | input | 5 | First vector register |
| cmd_base_reg | input | 4 | Base register number |
| cmd_idx_reg | input | 4 | Index register number |
| cmd_big_endian | input | 1 | Data is big-endian |
| cmd_base_val | input | ADDR_W | Base register value |
| cmd_idx_val | input | ADDR_W | Index register value |
| busy | output | 1 | Command in progress |
| illegal | output | 1 | Command rejected (one cycle) |
| done | output | 1 | Command finished (one cycle) |
| wb_en | output | 1 | Base writeback valid with done |
| wb_reg | output | 4 | Register to write back |
| wb_value | output | ADDR_W | New base value |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request taken |
| mem_write | output | 1 | Request is a store |
| mem_addr | output | ADDR_W | Access address |
| mem_size | output | 2 | log2 of access bytes |
| mem_wdata | output | 64 | Store element, right-aligned |
| mem_rvalid | input | 1 | Load response valid |
| mem_rdata | input | 64 | Load element, right-aligned |
| rf_rd_en | output | 1 | Register element read |
| rf_rd_reg | output | 5 | Read register |
| rf_rd_elem | output | 3 | Read element index |
| rf_rd_size | output | 2 | Read element size |
| rf_rd_data | input | 64 | Read element, same cycle |
| rf_wr_en | output | 1 | Register element write |
| rf_wr_reg | output | 5 | Write register |
| rf_wr_elem | output | 3 | Write element index |
| rf_wr_size | output | 2 | Write element size |
| rf_wr_data | output | 64 | Write element data |

## Verification
Table-driven commands cover every layout family:

- **Four-way and three-way interleaves** with spacing 1 and 2. These separate the innermost loop from the middle loop and confirm the spacing in the register numbers.
- **Multi-register contiguous layouts**, both little-endian (promoted to single doubleword moves) and big-endian word-sized (not promoted). These tell the promotion rule apart from the plain walk.
- **A byte-sized big-endian transfer**, which confirms that byte elements ignore the endian flag.

Illegal commands touch each legality rule alone, including alignment hints on both sides of each limit. Each command is checked on the full memory and register images and on the exact request sequence, so misordered loops or a wrong address step both show up. A command pulsed in mid-transfer checks that the block ignores it while busy.

// File: rtl/vst_pkg.sv
package vst_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH,
        S_REQ,
        S_RESP,
        S_FINISH
    } vst_state_e;

    typedef struct packed {
        logic [2:0] nregs;
        logic [2:0] ilv;
        logic [1:0] spacing;
    } vst_layout_t;

    localparam logic [3:0] WB_NONE = 4'd15;
    localparam logic [3:0] WB_IMM  = 4'd13;
    localparam logic [3:0] MAX_CODE = 4'd10;

    function automatic vst_layout_t vst_layout_of(input logic [3:0] code);
        vst_layout_t l;
        case (code)
            4'd0:    l = '{3'd1, 3'd4, 2'd1};
            4'd1:    l = '{3'd1, 3'd4, 2'd2};
            4'd2:    l = '{3'd4, 3'd1, 2'd1};
            4'd3:    l = '{3'd2, 3'd2, 2'd2};
            4'd4:    l = '{3'd1, 3'd3, 2'd1};
            4'd5:    l = '{3'd1, 3'd3, 2'd2};
            4'd6:    l = '{3'd3, 3'd1, 2'd1};
            4'd8:    l = '{3'd1, 3'd2, 2'd1};
            4'd9:    l = '{3'd1, 3'd2, 2'd2};
            4'd10:   l = '{3'd2, 3'd1, 2'd1};
            default: l = '{3'd1, 3'd1, 2'd1};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/vst_decode.sv
module vst_decode
    import vst_pkg::*;
#(
    parameter int VREGS = 32
) (
    input  logic [3:0]  code,
    input  logic [1:0]  size,
    input  logic [1:0]  align,
    input  logic        vd_high,
    input  logic        big_endian,
    output vst_layout_t layout,
    output logic [1:0]  esize,
    output logic [7:0]  stride,
    output logic        bad
);
    localparam logic NARROW_BANK = (VREGS <= 16);

    logic over_range;
    logic align_bad;
    logic size_bad;
    logic bank_bad;
    logic promote;
    logic [7:0] units;

    always_comb begin
        layout     = vst_layout_of(code);
        over_range = (code > MAX_CODE);
        align_bad  = ((code[3:2] == 2'b01) && (align >= 2'd2)) ||
                     ((code[3:2] == 2'b10) && (align == 2'd3));
        size_bad   = (size == 2'd3) &&
                     ((layout.ilv != 3'd1) || (layout.spacing != 2'd1));
        bank_bad   = NARROW_BANK && vd_high;
        bad        = over_range | align_bad | size_bad | bank_bad;

        promote    = (layout.ilv == 3'd1) && ((size == 2'd0) || !big_endian);
        esize      = promote ? 2'd3 : size;

        units      = 8'(layout.nregs) * 8'(layout.ilv);
        stride     = units << 3;
    end

endmodule

// File: rtl/vst_walker.sv
module vst_walker
    import vst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  vst_layout_t       layout,
    input  logic [1:0]        esize,
    input  logic [4:0]        first_reg,
    output logic [ADDR_W-1:0] addr,
    output logic [4:0]        tgt_reg,
    output logic [2:0]        elem,
    output logic              last
);
    logic [1:0] r_i;
    logic [1:0] x_i;
    logic [2:0] e_i;
    logic [3:0] ecount;
    logic [2:0] emax;
    logic       r_end;
    logic       x_end;
    logic       e_end;
    logic [4:0] hop;

    always_comb begin
        ecount  = 4'd8 >> esize;
        emax    = 3'(ecount - 4'd1);
        r_end   = ({1'b0, r_i} == (layout.nregs - 3'd1));
        x_end   = ({1'b0, x_i} == (layout.ilv - 3'd1));
        e_end   = (e_i == emax);
        last    = r_end && e_end && x_end;
        hop     = 5'(layout.spacing) * 5'(x_i);
        tgt_reg = first_reg + 5'(r_i) + hop;
        elem    = e_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_i  <= '0;
            x_i  <= '0;
            e_i  <= '0;
            addr <= '0;
        end else if (start) begin
            r_i  <= '0;
            x_i  <= '0;
            e_i  <= '0;
            addr <= base;
        end else if (step) begin
            addr <= addr + (ADDR_W'(1) << esize);
            if (!x_end) begin
                x_i <= x_i + 2'd1;
            end else begin
                x_i <= '0;
                if (!e_end) begin
                    e_i <= e_i + 3'd1;
                end else begin
                    e_i <= '0;
                    r_i <= r_i + 2'd1;
                end
            end
        end
    end

    // R5: element counter never passes the element count of the size
    assert_elem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (e_i <= emax));

endmodule

// File: rtl/vst_wb.sv
module vst_wb
    import vst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [3:0]        idx_reg,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] idx_val,
    input  logic [7:0]        stride,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_value
);
    logic [ADDR_W-1:0] inc;

    always_comb begin
        wb_en    = (idx_reg != WB_NONE);
        inc      = (idx_reg == WB_IMM) ? ADDR_W'(stride) : idx_val;
        wb_value = base + inc;
    end

endmodule

// File: rtl/vst_seq.sv
module vst_seq
    import vst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VREGS  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_load,
    input  logic [3:0]        cmd_type,
    input  logic [1:0]        cmd_size,
    input  logic [1:0]        cmd_align,
    input  logic [4:0]        cmd_vd,
    input  logic [3:0]        cmd_base_reg,
    input  logic [3:0]        cmd_idx_reg,
    input  logic              cmd_big_endian,
    input  logic [ADDR_W-1:0] cmd_base_val,
    input  logic [ADDR_W-1:0] cmd_idx_val,
    output logic              busy,
    output logic              illegal,
    output logic              done,
    output logic              wb_en,
    output logic [3:0]        wb_reg,
    output logic [ADDR_W-1:0] wb_value,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [63:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              rf_rd_en,
    output logic [4:0]        rf_rd_reg,
    output logic [2:0]        rf_rd_elem,
    output logic [1:0]        rf_rd_size,
    input  logic [63:0]       rf_rd_data,
    output logic              rf_wr_en,
    output logic [4:0]        rf_wr_reg,
    output logic [2:0]        rf_wr_elem,
    output logic [1:0]        rf_wr_size,
    output logic [63:0]       rf_wr_data
);
    vst_state_e state, state_nx;

    logic              c_load;
    logic              c_be;
    logic [3:0]        c_type;
    logic [1:0]        c_size;
    logic [1:0]        c_align;
    logic [4:0]        c_vd;
    logic [3:0]        c_rn;
    logic [3:0]        c_rm;
    logic [ADDR_W-1:0] c_base;
    logic [ADDR_W-1:0] c_idx;
    logic [63:0]       st_data;

    vst_layout_t       layout;
    logic [1:0]        esize;
    logic [7:0]        stride;
    logic              bad;
    logic              w_start;
    logic              w_step;
    logic [ADDR_W-1:0] w_addr;
    logic [4:0]        w_reg;
    logic [2:0]        w_elem;
    logic              w_last;
    logic              wb_want;
    logic [ADDR_W-1:0] wb_calc;

    vst_decode #(.VREGS(VREGS)) u_decode (
        .code       (c_type),
        .size       (c_size),
        .align      (c_align),
        .vd_high    (c_vd[4]),
        .big_endian (c_be),
        .layout     (layout),
        .esize      (esize),
        .stride     (stride),
        .bad        (bad)
    );

    vst_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (w_start),
        .step      (w_step),
        .base      (c_base),
        .layout    (layout),
        .esize     (esize),
        .first_reg (c_vd),
        .addr      (w_addr),
        .tgt_reg   (w_reg),
        .elem      (w_elem),
        .last      (w_last)
    );

    vst_wb #(.ADDR_W(ADDR_W)) u_wb (
        .idx_reg  (c_rm),
        .base     (c_base),
        .idx_val  (c_idx),
        .stride   (stride),
        .wb_en    (wb_want),
        .wb_value (wb_calc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // command and store-data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_load  <= 1'b0;
            c_be    <= 1'b0;
            c_type  <= '0;
            c_size  <= '0;
            c_align <= '0;
            c_vd    <= '0;
            c_rn    <= '0;
            c_rm    <= '0;
            c_base  <= '0;
            c_idx   <= '0;
            st_data <= '0;
        end else begin
            if (state == S_IDLE && cmd_valid) begin
                c_load  <= cmd_load;
                c_be    <= cmd_big_endian;
                c_type  <= cmd_type;
                c_size  <= cmd_size;
                c_align <= cmd_align;
                c_vd    <= cmd_vd;
                c_rn    <= cmd_base_reg;
                c_rm    <= cmd_idx_reg;
                c_base  <= cmd_base_val;
                c_idx   <= cmd_idx_val;
            end
            if (state == S_FETCH) st_data <= rf_rd_data;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (cmd_valid) state_nx = S_CHECK;
            S_CHECK: begin
                if (bad)         state_nx = S_IDLE;
                else if (c_load) state_nx = S_REQ;
                else             state_nx = S_FETCH;
            end
            S_FETCH:  state_nx = S_REQ;
            S_REQ: begin
                if (mem_ready) begin
                    if (c_load)      state_nx = S_RESP;
                    else if (w_last) state_nx = S_FINISH;
                    else             state_nx = S_FETCH;
                end
            end
            S_RESP: begin
                if (mem_rvalid) state_nx = w_last ? S_FINISH : S_REQ;
            end
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready  = (state == S_IDLE);
        busy       = (state != S_IDLE);
        illegal    = (state == S_CHECK) && bad;
        done       = (state == S_FINISH);
        wb_en      = done && wb_want;
        wb_reg     = c_rn;
        wb_value   = wb_calc;

        w_start    = (state == S_CHECK);
        w_step     = ((state == S_REQ) && mem_ready && !c_load) ||
                     ((state == S_RESP) && mem_rvalid);

        mem_valid  = (state == S_REQ);
        mem_write  = !c_load;
        mem_addr   = w_addr;
        mem_size   = esize;
        mem_wdata  = st_data;

        rf_rd_en   = (state == S_FETCH);
        rf_rd_reg  = w_reg;
        rf_rd_elem = w_elem;
        rf_rd_size = esize;

        rf_wr_en   = (state == S_RESP) && mem_rvalid;
        rf_wr_reg  = w_reg;
        rf_wr_elem = w_elem;
        rf_wr_size = esize;
        rf_wr_data = mem_rdata;
    end

    // R10: request held stable while not accepted
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
            $stable(mem_size) && $stable(mem_wdata) && $stable(mem_write)));

    // R10: register write only while no request is outstanding
    assert_wr_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (!mem_valid && !mem_write));

    // R9: rejection is one cycle and leaves the block idle
    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (!busy && !mem_valid && !illegal && !done));

    // R11: busy rises only from an accepted command
    assert_accept_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) && $past(cmd_ready)));

    // R11: done ends the command
    assert_done_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R8: writeback only alongside done
    assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

endmodule

// File: tb/vst_seq_test.sv
module vst_seq_test;
    typedef struct packed {
        logic       ld;
        logic [3:0] ty;
        logic [1:0] sz;
        logic [1:0] al;
        logic [4:0] vd;
        logic [3:0] rm;
        logic       be;
        logic [7:0] base;
        logic [7:0] idx;
        logic       bad;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd7,  2'd0, 2'd0, 5'd2,  4'd15, 1'b0, 8'd16,  8'd0,   1'b0, 8'd7},  // R7 promoted single
        '{1'b1, 4'd0,  2'd1, 2'd0, 5'd0,  4'd13, 1'b0, 8'd32,  8'd0,   1'b0, 8'd5},  // R5 four-way
        '{1'b0, 4'd1,  2'd0, 2'd0, 5'd4,  4'd3,  1'b0, 8'd40,  8'd100, 1'b0, 8'd8},  // R8 index add, R12
        '{1'b1, 4'd2,  2'd2, 2'd0, 5'd1,  4'd13, 1'b1, 8'd80,  8'd0,   1'b0, 8'd7},  // R7 not promoted
        '{1'b0, 4'd3,  2'd1, 2'd0, 5'd3,  4'd15, 1'b0, 8'd120, 8'd0,   1'b0, 8'd5},  // R5 two regs spaced
        '{1'b1, 4'd5,  2'd2, 2'd1, 5'd0,  4'd13, 1'b0, 8'd150, 8'd0,   1'b0, 8'd2},  // R2 legal hint
        '{1'b1, 4'd9,  2'd0, 2'd2, 5'd8,  4'd15, 1'b1, 8'd180, 8'd0,   1'b0, 8'd6},  // R6 byte steps
        '{1'b0, 4'd6,  2'd3, 2'd0, 5'd12, 4'd13, 1'b0, 8'd200, 8'd0,   1'b0, 8'd3},  // R3 legal size 3
        '{1'b1, 4'd11, 2'd0, 2'd0, 5'd0,  4'd15, 1'b0, 8'd0,   8'd0,   1'b1, 8'd1},  // R1 code 11
        '{1'b1, 4'd4,  2'd0, 2'd2, 5'd0,  4'd15, 1'b0, 8'd0,   8'd0,   1'b1, 8'd2},  // R2 01 with 2
        '{1'b0, 4'd8,  2'd0, 2'd3, 5'd0,  4'd15, 1'b0, 8'd0,   8'd0,   1'b1, 8'd2},  // R2 10 with 3
        '{1'b1, 4'd0,  2'd3, 2'd0, 5'd0,  4'd15, 1'b0, 8'd0,   8'd0,   1'b1, 8'd3},  // R3 size 3 interleaved
        '{1'b1, 4'd7,  2'd0, 2'd0, 5'd16, 4'd15, 1'b0, 8'd0,   8'd0,   1'b1, 8'd4},  // R4 high bank
        '{1'b1, 4'd8,  2'd2, 2'd2, 5'd5,  4'd13, 1'b0, 8'd8,   8'd0,   1'b0, 8'd1}   // R1 code 8 layout
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        cmd_valid, cmd_ready, cmd_load, cmd_big_endian;
    logic [3:0]  cmd_type, cmd_base_reg, cmd_idx_reg;
    logic [1:0]  cmd_size, cmd_align;
    logic [4:0]  cmd_vd;
    logic [31:0] cmd_base_val, cmd_idx_val;
    logic        busy, illegal, done, wb_en;
    logic [3:0]  wb_reg;
    logic [31:0] wb_value;
    logic        mem_valid, mem_ready, mem_write, mem_rvalid;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [63:0] mem_wdata, mem_rdata;
    logic        rf_rd_en, rf_wr_en;
    logic [4:0]  rf_rd_reg, rf_wr_reg;
    logic [2:0]  rf_rd_elem, rf_wr_elem;
    logic [1:0]  rf_rd_size, rf_wr_size;
    logic [63:0] rf_rd_data, rf_wr_data;

    vst_seq #(.ADDR_W(32), .VREGS(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_load(cmd_load),
        .cmd_type(cmd_type), .cmd_size(cmd_size), .cmd_align(cmd_align),
        .cmd_vd(cmd_vd), .cmd_base_reg(cmd_base_reg), .cmd_idx_reg(cmd_idx_reg),
        .cmd_big_endian(cmd_big_endian), .cmd_base_val(cmd_base_val),
        .cmd_idx_val(cmd_idx_val), .busy(busy), .illegal(illegal), .done(done),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_value(wb_value),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rf_rd_en(rf_rd_en), .rf_rd_reg(rf_rd_reg), .rf_rd_elem(rf_rd_elem),
        .rf_rd_size(rf_rd_size), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_reg(rf_wr_reg), .rf_wr_elem(rf_wr_elem),
        .rf_wr_size(rf_wr_size), .rf_wr_data(rf_wr_data)
    );

    logic [7:0]  mem [256];
    logic [63:0] vr [32];
    logic [7:0]  exp_mem [256];
    logic [63:0] exp_vr [32];
    logic [31:0] exp_addr [64];
    logic [4:0]  exp_reg [64];
    logic [2:0]  exp_elem [64];
    logic [1:0]  exp_sz;
    int          exp_n;
    int          acc_n, acc_bad, wr_n, wr_bad;
    logic [3:0]  stall = 4'd0;
    int          n_chk = 0;
    int          n_fail = 0;

    assign mem_ready = (stall[1:0] != 2'b01);

    function automatic logic [63:0] size_mask(input logic [1:0] s);
        return (s == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << s)) - 64'd1);
    endfunction

    always_comb begin
        rf_rd_data = (vr[rf_rd_reg] >> (int'(rf_rd_elem) * (8 << rf_rd_size)))
                     & size_mask(rf_rd_size);
    end

    // memory and register file model
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            logic [63:0] rd;
            int nb;
            int off;
            stall      <= stall + 4'd1;
            mem_rvalid <= 1'b0;
            if (mem_valid && mem_ready) begin
                if (acc_n >= exp_n || mem_addr !== exp_addr[acc_n] || mem_size !== exp_sz)
                    acc_bad++;
                nb = 1 << mem_size;
                rd = '0;
                for (int b = 0; b < nb; b++) begin
                    if (mem_write) mem[8'(mem_addr + 32'(b))] = mem_wdata[8*b +: 8];
                    else           rd[8*b +: 8] = mem[8'(mem_addr + 32'(b))];
                end
                if (!mem_write) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= rd;
                end
                acc_n++;
            end
            if (rf_wr_en) begin
                if (wr_n >= exp_n || rf_wr_reg !== exp_reg[wr_n] ||
                    rf_wr_elem !== exp_elem[wr_n])
                    wr_bad++;
                off = int'(rf_wr_elem) * (8 << rf_wr_size);
                vr[rf_wr_reg] = (vr[rf_wr_reg] & ~(size_mask(rf_wr_size) << off)) |
                                ((rf_wr_data & size_mask(rf_wr_size)) << off);
                wr_n++;
            end
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic lay(input logic [3:0] ty, output int nr, output int il, output int sp);
        case (ty)
            4'd0: begin nr = 1; il = 4; sp = 1; end
            4'd1: begin nr = 1; il = 4; sp = 2; end
            4'd2: begin nr = 4; il = 1; sp = 1; end
            4'd3: begin nr = 2; il = 2; sp = 2; end
            4'd4: begin nr = 1; il = 3; sp = 1; end
            4'd5: begin nr = 1; il = 3; sp = 2; end
            4'd6: begin nr = 3; il = 1; sp = 1; end
            4'd8: begin nr = 1; il = 2; sp = 1; end
            4'd9: begin nr = 1; il = 2; sp = 2; end
            4'd10: begin nr = 2; il = 1; sp = 1; end
            default: begin nr = 1; il = 1; sp = 1; end
        endcase
    endtask

    logic [31:0] exp_wb;
    logic        exp_wb_en;

    task automatic build_exp(input vec_t v);
        int nr, il, sp, es, nb, eb;
        logic [31:0] a;
        logic [4:0] r5;
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        for (int i = 0; i < 32; i++) exp_vr[i] = vr[i];
        exp_n = 0; acc_n = 0; acc_bad = 0; wr_n = 0; wr_bad = 0;
        lay(v.ty, nr, il, sp);
        es = (il == 1 && (v.sz == 2'd0 || !v.be)) ? 3 : int'(v.sz);
        exp_sz = 2'(es);
        nb = 1 << es;
        exp_wb_en = (v.rm != 4'd15);
        exp_wb = 32'(v.base) + ((v.rm == 4'd13) ? 32'(nr * il * 8) : 32'(v.idx));
        if (v.bad) return;
        for (int r = 0; r < nr; r++)
            for (int e = 0; e < (8 >> es); e++)
                for (int x = 0; x < il; x++) begin
                    a  = 32'(v.base) + 32'(exp_n * nb);
                    r5 = 5'(int'(v.vd) + r + sp * x);
                    exp_addr[exp_n] = a;
                    exp_reg[exp_n]  = r5;
                    exp_elem[exp_n] = 3'(e);
                    for (int b = 0; b < nb; b++) begin
                        eb = e * nb * 8 + 8 * b;
                        if (v.ld) exp_vr[r5][eb +: 8] = exp_mem[8'(a + 32'(b))];
                        else      exp_mem[8'(a + 32'(b))] = exp_vr[r5][eb +: 8];
                    end
                    exp_n++;
                end
    endtask

    int ill_cyc, done_cyc, busy_cyc, idle_gap;
    logic seen_wb_en;
    logic [31:0] seen_wb;
    logic [3:0] seen_wb_reg;

    task automatic run_cmd(input vec_t v, input bit inject);
        int cyc;
        ill_cyc = 0; done_cyc = 0; busy_cyc = 0; idle_gap = 0;
        seen_wb_en = 1'b0; seen_wb = '0; seen_wb_reg = '0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_load = v.ld; cmd_type = v.ty; cmd_size = v.sz;
        cmd_align = v.al; cmd_vd = v.vd; cmd_base_reg = 4'd9; cmd_idx_reg = v.rm;
        cmd_big_endian = v.be; cmd_base_val = 32'(v.base); cmd_idx_val = 32'(v.idx);
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (cyc < 2000) begin
            if (illegal) ill_cyc++;
            if (busy) busy_cyc++;
            if (done) begin
                done_cyc++;
                seen_wb_en = wb_en;
                seen_wb = wb_value;
                seen_wb_reg = wb_reg;
            end
            if (!busy) break;
            if (inject && cyc == 3) begin
                cmd_valid = 1'b1; cmd_type = 4'd12;
            end
            if (inject && cyc == 5) cmd_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        cmd_valid = 1'b0;
        // one idle cycle: nothing must start from a command offered while busy
        @(negedge clk);
        if (busy || illegal) idle_gap++;
    endtask

    task automatic verify(input vec_t v, input string tag);
        int mem_bad, vr_bad;
        mem_bad = 0; vr_bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mem_bad++;
        for (int i = 0; i < 32; i++) if (vr[i] !== exp_vr[i]) vr_bad++;
        if (v.bad) begin
            check(ill_cyc == 1, {tag, " R9 illegal one cycle"}, 64'(ill_cyc), 64'd1);
            check(acc_n == 0 && done_cyc == 0, {tag, " R9 no access no done"},
                  64'(acc_n + done_cyc), 64'd0);
            check(mem_bad == 0 && vr_bad == 0, {tag, " R9 state untouched"},
                  64'(mem_bad + vr_bad), 64'd0);
        end else begin
            check(ill_cyc == 0 && done_cyc == 1, {tag, " R11 single done"},
                  64'(done_cyc), 64'd1);
            check(acc_n == exp_n && acc_bad == 0, {tag, " R5 R6 R7 access sequence"},
                  64'(acc_n), 64'(exp_n));
            check(v.ld ? (wr_n == exp_n && wr_bad == 0) : (wr_n == 0),
                  {tag, " R5 R10 register targets"}, 64'(wr_bad), 64'd0);
            check(mem_bad == 0 && vr_bad == 0, {tag, " R10 R12 data images"},
                  64'(mem_bad + vr_bad), 64'd0);
            check(seen_wb_en == exp_wb_en &&
                  (!exp_wb_en || (seen_wb == exp_wb && seen_wb_reg == 4'd9)),
                  {tag, " R8 writeback"}, 64'(seen_wb), 64'(exp_wb));
            check(busy_cyc == 0 ? 1'b0 : 1'b1, {tag, " R11 busy while running"},
                  64'(busy_cyc), 64'd1);
        end
        check(idle_gap == 0, {tag, " R11 idle after end"}, 64'(idle_gap), 64'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        for (int r = 0; r < 32; r++)
            for (int k = 0; k < 8; k++) vr[r][8*k +: 8] = 8'(r * 16 + k + 128);
        exp_n = 0; acc_n = 0; acc_bad = 0; wr_n = 0; wr_bad = 0; exp_sz = '0;
        rst_n = 1'b0;
        cmd_valid = 1'b0; cmd_load = 1'b0; cmd_type = '0; cmd_size = '0;
        cmd_align = '0; cmd_vd = '0; cmd_base_reg = '0; cmd_idx_reg = '0;
        cmd_big_endian = 1'b0; cmd_base_val = '0; cmd_idx_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R11, R9)
        check(cmd_ready && !busy, "R11 reset idle", {62'd0, cmd_ready, busy}, 64'h2);
        check(!done && !illegal && !mem_valid && !rf_wr_en && !rf_rd_en,
              "R9 reset outputs quiet",
              {59'd0, done, illegal, mem_valid, rf_wr_en, rf_rd_en}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("vec%0d R%0d", i, VEC[i].req);
            build_exp(VEC[i]);
            run_cmd(VEC[i], 1'b0);
            verify(VEC[i], tag);
        end

        // R11: command offered mid-transfer is ignored; the store completes as planned
        begin
            vec_t v;
            v = VEC[2];
            v.base = 8'd60;
            build_exp(v);
            run_cmd(v, 1'b1);
            verify(v, "busy-inject R11");
            check(ill_cyc == 0, "R11 ignored command not decoded", 64'(ill_cyc), 64'd0);
        end

        // R7 corner: big-endian byte elements with interleave 1 still promote
        begin
            vec_t v;
            v = '{1'b1, 4'd10, 2'd0, 2'd0, 5'd6, 4'd13, 1'b1, 8'd96, 8'd0, 1'b0, 8'd7};
            build_exp(v);
            run_cmd(v, 1'b0);
            verify(v, "byte-be R7");
            check(acc_n == 2, "R7 byte promotion count", 64'(acc_n), 64'd2);
        end

        summary();
        $finish;
    end

endmodule